// File: doc/BRIEF.md
# Packet-Driven LIFO Stack Element

This block is a processing element that sits on one port of an on-chip packet ring and keeps a last-in first-out store of 32-bit values. Other elements talk to it only through 80-bit request packets. Each request carries a value, an opcode, the address of the element that sent it and the address of this element. Every answer leaves as a reply packet. In a reply the two address fields are swapped: this element's own address goes in as the source, and the requester's address goes in as the destination.

A push adds one value. A pop names in its value field how many entries to remove, and the element returns one reply per removed entry, starting with the entry on top. A clear empties the store. A push to a full store gets an error reply. So does a pop that asks for more entries than the store holds, and in both cases the store is left as it was. One request is handled at a time: the inbound port refuses a new packet until the last reply of the current request has been taken on the outbound port. Both ports use a valid/ready handshake.

Top module: `stack_pe`

## Requirements
- R1: After reset, and after any later reset, out_valid is 0, in_ready is 1 and the store is empty, so a following pop of 1 returns an ERR_EMPTY reply.
- R2: Every packet places the value in bits 79:48, the opcode in bits 47:32, the source address in bits 31:16 and the destination address in bits 15:0. Every reply carries SELF_ADDR (default 0x0003) as its source and the source address of the request being served as its destination. The opcodes are PUSH=0x0001, POP=0x0002, CLEAR=0x0003, SUCCESS=0x0100, ERR_EMPTY=0x0201 and ERR_FULL=0x0202.
- R3: A PUSH to a store that is not full stores the value and returns one SUCCESS reply that carries the same value.
- R4: A PUSH to a store that already holds DEPTH entries (default 16) returns one ERR_FULL reply that carries the pushed value, and it leaves the store's contents unchanged.
- R5: A POP with a count N where 1 ≤ N ≤ current depth returns N SUCCESS replies, one after another. The first carries the top entry, each following one carries the next entry down, and each reply removes the entry it carries.
- R6: A POP whose count is greater than the current depth returns one ERR_EMPTY reply that carries the count, and it removes nothing.
- R7: A POP with a count of 0 returns one SUCCESS reply with value 0 and removes nothing.
- R8: A CLEAR sets the depth to zero and returns one SUCCESS reply with value 0.
- R9: in_ready goes low in the cycle after a request is accepted. It stays low until the handshake of that request's last reply, and it is high again in the cycle after that handshake.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_pkt does not change.
- R11: A request with any other opcode is accepted, produces no reply and leaves the store unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request packet is present |
| in_ready | output | 1 | Element can take a request |
| in_pkt | input | 80 | Request packet |
| out_valid | output | 1 | Reply packet is present |
| out_ready | input | 1 | Receiver takes the reply |
| out_pkt | output | 80 | Reply packet |

## Verification
The bench pops twice from a three-entry store. A design that pops from the wrong end, or that gives up after the first reply, sends the wrong value or too few replies. It then pops more than the store holds and pops zero, and finishes with a pop of one. A design that removes entries before checking the count returns the wrong last value. It fills the store to the limit and pushes once more. A design with an off-by-one limit either accepts the extra value or overwrites the top, and the next pop shows which. Finally it holds out_ready low in the middle of a two-reply pop, which catches a design that drops or changes a pending reply, or one that lets a new request in early.

// File: rtl/stack_pe_pkg.sv
package stack_pe_pkg;
    localparam int VAL_W  = 32;
    localparam int OP_W   = 16;
    localparam int NODE_W = 16;
    localparam int PKT_W  = VAL_W + OP_W + 2 * NODE_W;

    typedef struct packed {
        logic [VAL_W-1:0]  val;
        logic [OP_W-1:0]   op;
        logic [NODE_W-1:0] src;
        logic [NODE_W-1:0] dst;
    } pkt_t;

    localparam logic [OP_W-1:0] OP_PUSH      = 16'h0001;
    localparam logic [OP_W-1:0] OP_POP       = 16'h0002;
    localparam logic [OP_W-1:0] OP_CLEAR     = 16'h0003;
    localparam logic [OP_W-1:0] OP_SUCCESS   = 16'h0100;
    localparam logic [OP_W-1:0] OP_ERR_EMPTY = 16'h0201;
    localparam logic [OP_W-1:0] OP_ERR_FULL  = 16'h0202;
endpackage

// File: rtl/stack_pe_store.sv
module stack_pe_store #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_val
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_val;
        end
    end

    assign rd_val = cells[rd_idx];
endmodule

// File: rtl/stack_pe_ctrl.sv
module stack_pe_ctrl
    import stack_pe_pkg::*;
#(
    parameter int                DEPTH     = 16,
    parameter logic [NODE_W-1:0] SELF_ADDR = 16'h0003,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  pkt_t             req,
    output logic             out_valid,
    input  logic             out_ready,
    output pkt_t             rsp,
    output logic [CNT_W-1:0] depth,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [VAL_W-1:0] wr_val,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [VAL_W-1:0] rd_val
);
    typedef struct packed {
        logic             busy;
        pkt_t             pkt;
        logic [CNT_W-1:0] fill;
        logic [CNT_W-1:0] left;
    } ctl_t;

    ctl_t s_d, s_q;
    logic take, sent, full;

    always_comb begin
        s_d    = s_q;
        take   = in_valid && !s_q.busy;
        sent   = s_q.busy && out_ready;
        full   = (s_q.fill == CNT_W'(DEPTH));
        wr_en  = 1'b0;
        wr_idx = IDX_W'(s_q.fill);
        wr_val = req.val;
        rd_idx = IDX_W'(s_q.fill - CNT_W'(1));

        // stream the remaining pop replies, top first
        if (sent) begin
            if (s_q.left != '0) begin
                s_d.pkt.val = rd_val;
                s_d.fill    = s_q.fill - CNT_W'(1);
                s_d.left    = s_q.left - CNT_W'(1);
            end else begin
                s_d.busy = 1'b0;
            end
        end

        if (take) begin
            s_d.pkt.src = SELF_ADDR;
            s_d.pkt.dst = req.src;
            s_d.pkt.op  = OP_SUCCESS;
            s_d.pkt.val = req.val;
            s_d.left    = '0;
            case (req.op)
                OP_PUSH: begin
                    s_d.busy = 1'b1;
                    if (full) begin
                        s_d.pkt.op = OP_ERR_FULL;
                    end else begin
                        wr_en    = 1'b1;
                        s_d.fill = s_q.fill + CNT_W'(1);
                    end
                end
                OP_POP: begin
                    s_d.busy = 1'b1;
                    if (req.val > VAL_W'(s_q.fill)) begin
                        s_d.pkt.op = OP_ERR_EMPTY;
                    end else if (req.val != '0) begin
                        s_d.pkt.val = rd_val;
                        s_d.fill    = s_q.fill - CNT_W'(1);
                        s_d.left    = CNT_W'(req.val - VAL_W'(1));
                    end
                end
                OP_CLEAR: begin
                    s_d.busy    = 1'b1;
                    s_d.fill    = '0;
                    s_d.pkt.val = '0;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = !s_q.busy;
    assign out_valid = s_q.busy;
    assign rsp       = s_q.pkt;
    assign depth     = s_q.fill;
endmodule

// File: rtl/stack_pe.sv
module stack_pe
    import stack_pe_pkg::*;
#(
    parameter int                DEPTH     = 16,
    parameter logic [NODE_W-1:0] SELF_ADDR = 16'h0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PKT_W-1:0] out_pkt
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    pkt_t             req, rsp;
    logic [CNT_W-1:0] depth;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [VAL_W-1:0] wr_val, rd_val;

    assign req     = pkt_t'(in_pkt);
    assign out_pkt = rsp;

    stack_pe_ctrl #(.DEPTH(DEPTH), .SELF_ADDR(SELF_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .req(req),
        .out_valid(out_valid), .out_ready(out_ready), .rsp(rsp),
        .depth(depth),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );

    stack_pe_store #(.DEPTH(DEPTH), .W(VAL_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );
endmodule

// File: rtl/stack_pe_chk.sv
module stack_pe_chk
    import stack_pe_pkg::*;
#(
    parameter int                DEPTH     = 16,
    parameter logic [NODE_W-1:0] SELF_ADDR = 16'h0003,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PKT_W-1:0] in_pkt,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PKT_W-1:0] out_pkt,
    input logic [CNT_W-1:0] depth
);
    pkt_t             rq, rp;
    logic [NODE_W-1:0] last_src;
    logic              acc;

    assign rq  = pkt_t'(in_pkt);
    assign rp  = pkt_t'(out_pkt);
    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_src <= '0;
        end else if (acc) begin
            last_src <= rq.src;
        end
    end

    // R10
    hold_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));

    // R9
    reply_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(acc));

    // R2
    reply_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rp.dst == last_src && rp.src == SELF_ADDR));

    // R2
    reply_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rp.op == OP_SUCCESS || rp.op == OP_ERR_EMPTY || rp.op == OP_ERR_FULL));

    // R4
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rq.op == OP_CLEAR) |=> (depth == '0));

    // R6
    underflow_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rq.op == OP_POP && rq.val > VAL_W'(depth)) |=> $stable(depth));
endmodule

bind stack_pe stack_pe_chk #(.DEPTH(DEPTH), .SELF_ADDR(SELF_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
    .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
    .depth(depth)
);

// File: tb/stack_pe_bench.sv
module stack_pe_bench;
    import stack_pe_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          NV         = 16;
    localparam logic [15:0] ME         = 16'h0003;
    localparam logic [15:0] NONE       = 16'h0000;

    // row: send, requester, op, value, expected op (NONE = no reply), expected value
    localparam logic [112:0] VEC [NV] = '{
        {1'b1, 16'h0007, OP_POP,   32'd1,     OP_ERR_EMPTY, 32'd1},
        {1'b1, 16'h0007, OP_PUSH,  32'h11,    OP_SUCCESS,   32'h11},
        {1'b1, 16'h0005, OP_PUSH,  32'h22,    OP_SUCCESS,   32'h22},
        {1'b1, 16'h0007, OP_PUSH,  32'h33,    OP_SUCCESS,   32'h33},
        {1'b1, 16'h0009, OP_POP,   32'd2,     OP_SUCCESS,   32'h33},
        {1'b0, 16'h0009, OP_POP,   32'd2,     OP_SUCCESS,   32'h22},
        {1'b1, 16'h0007, OP_POP,   32'd3,     OP_ERR_EMPTY, 32'd3},
        {1'b1, 16'h0007, OP_POP,   32'd0,     OP_SUCCESS,   32'd0},
        {1'b1, 16'h0006, OP_POP,   32'd1,     OP_SUCCESS,   32'h11},
        {1'b1, 16'h0006, OP_PUSH,  32'h0A,    OP_SUCCESS,   32'h0A},
        {1'b1, 16'h0006, OP_PUSH,  32'h0B,    OP_SUCCESS,   32'h0B},
        {1'b1, 16'h0004, OP_CLEAR, 32'h1234,  OP_SUCCESS,   32'd0},
        {1'b1, 16'h0004, OP_POP,   32'd1,     OP_ERR_EMPTY, 32'd1},
        {1'b1, 16'h0002, OP_PUSH,  32'h05,    OP_SUCCESS,   32'h05},
        {1'b1, 16'h0002, 16'h00FF, 32'h09,    NONE,         32'd0},
        {1'b1, 16'h0002, OP_POP,   32'd1,     OP_SUCCESS,   32'h05}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PKT_W-1:0] in_pkt = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [PKT_W-1:0] out_pkt;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    stack_pe u_stack_pe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
        .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(string tag, logic [79:0] act, logic [79:0] exp);
        compared = compared + 1;
        if (act !== exp) begin
            mismatched = mismatched + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called and returns at a falling edge
    task automatic send(logic [15:0] src, logic [15:0] op, logic [31:0] val);
        in_pkt   = {val, op, src, ME};
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic get_reply(string tag, logic [15:0] eop, logic [31:0] eval, logic [15:0] edst);
        int waited = 0;
        while (!out_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check(tag, 80'(out_valid), 80'(1'b1));
        check(tag, {32'd0, out_pkt[79:32]}, {32'd0, eval, eop});
        check("R2", 80'(out_pkt[31:0]), 80'({ME, edst}));
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", 80'({out_valid, in_ready}), 80'(2'b01));
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [112:0] r;
            string tag;
            r = VEC[i];
            if (r[47:32] == NONE)                  tag = "R11";
            else if (i == 0)                        tag = "R1";
            else if (r[95:80] == OP_PUSH)           tag = "R3";
            else if (r[95:80] == OP_CLEAR)          tag = "R8";
            else if (r[47:32] == OP_ERR_EMPTY)      tag = "R6";
            else if (r[79:48] == 32'd0)             tag = "R7";
            else                                    tag = "R5";
            if (r[112]) send(r[111:96], r[95:80], r[79:48]);
            if (r[47:32] == NONE) begin
                repeat (4) @(negedge clk);
                check(tag, 80'({out_valid, in_ready}), 80'(2'b01));
            end else begin
                get_reply(tag, r[47:32], r[31:0], r[111:96]);
            end
        end

        // R4 fill to the limit, then overflow
        for (int k = 0; k < 16; k++) begin
            send(16'h000A, OP_PUSH, 32'h100 + k);
            get_reply("R3", OP_SUCCESS, 32'h100 + k, 16'h000A);
        end
        send(16'h000B, OP_PUSH, 32'hDEAD);
        get_reply("R4", OP_ERR_FULL, 32'hDEAD, 16'h000B);
        send(16'h000B, OP_POP, 32'd1);
        get_reply("R4", OP_SUCCESS, 32'h10F, 16'h000B);
        send(16'h000B, OP_CLEAR, 32'd0);
        get_reply("R8", OP_SUCCESS, 32'd0, 16'h000B);

        // R9 and R10 backpressure during a two-reply pop
        send(16'h0008, OP_PUSH, 32'h77);
        get_reply("R3", OP_SUCCESS, 32'h77, 16'h0008);
        send(16'h0008, OP_PUSH, 32'h88);
        get_reply("R3", OP_SUCCESS, 32'h88, 16'h0008);
        send(16'h0008, OP_POP, 32'd2);
        in_pkt   = {32'h55, OP_PUSH, 16'h0001, ME};
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", 80'(out_valid), 80'(1'b1));
        check("R10", out_pkt, {32'h88, OP_SUCCESS, ME, 16'h0008});
        check("R9", 80'(in_ready), 80'(1'b0));
        in_valid = 1'b0;
        get_reply("R5", OP_SUCCESS, 32'h88, 16'h0008);
        check("R9", 80'(in_ready), 80'(1'b0));
        get_reply("R5", OP_SUCCESS, 32'h77, 16'h0008);
        check("R9", 80'({out_valid, in_ready}), 80'(2'b01));

        // R1 reset in mid-run empties the store
        send(16'h0003, OP_PUSH, 32'h99);
        get_reply("R3", OP_SUCCESS, 32'h99, 16'h0003);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", 80'({out_valid, in_ready}), 80'(2'b01));
        rst_n = 1'b1;
        @(negedge clk);
        send(16'h0003, OP_POP, 32'd1);
        get_reply("R1", OP_ERR_EMPTY, 32'd1, 16'h0003);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule